// File: doc/BRIEF.md
# Two-Step Subranging Converter Sequencer

This block is the digital half of a two-step flash analog-to-digital converter. It runs a fixed three-clock schedule that drives the track-and-hold, the comparator strobe and auto-zero, and the sample and amplify phases of the residue amplifier. It uses a single thermometer encoder twice in every conversion. The first pass reads the coarse comparator result, which gives the upper half of the word and the ladder tap that the residue stage subtracts. The second pass reads the amplified residue, which gives the lower half of the word.

The coarse and fine codes are held in a first register stage. Once a conversion's fine code is present, the whole word and its out-of-range flag move to an output register. In that same edge the next conversion's coarse code takes the first stage, so conversions overlap and a new result arrives every three clocks.

The result leaves as a valid-only stream. The converter never stalls, so there is no ready input and no back-pressure. A consumer must take `out_word` and `out_ovr` in the single cycle in which `out_valid` is high, because the next result overwrites them three clocks later. Each clock of the schedule stands for two half-clock analog phases. The comparator pins show which phase runs during each clock.

Top module: `two_step_adc_seq`

## Requirements
- R1: After reset the schedule repeats every three clocks: capture (phase 0), settle (phase 1), resolve (phase 2). Phase 0 is the first phase after reset. In phase 0 `th_hold`, `cmp_strobe` and `res_sample` are high. In phase 1 `cmp_autozero` and `res_amplify` are high. In phase 2 `cmp_strobe` and `res_amplify` are high. Every other phase pin is low.
- R2: When comparator bit 32 is low and at least one bit is high, the 5-bit code is the index of the highest high bit among bits 0..31. A single low bit (bubble) below the top of the thermometer does not change the code.
- R3: If no comparator bit is high, the code is 0 and out-of-range is set. If bit 32 is high, the code is 31 and out-of-range is set.
- R4: The coarse code is taken at the clock edge that ends phase 0. It appears on `tap_sel` from that edge until the next phase-0 edge.
- R5: The fine code is taken at the clock edge that ends phase 2. The comparator input is ignored during phase 1.
- R6: When the coarse pass is in range, `out_word` is {coarse XOR 5'b10000, fine}, which is two's complement with bit 9 as the sign. `out_ovr` then equals the fine pass's out-of-range flag.
- R7: When the coarse pass is out of range, `out_word` saturates to 10'h200 (below range) or 10'h1FF (above range), and `out_ovr` is 1.
- R8: The output register loads at the phase-0 edge that follows a fine capture. `out_valid` is high for exactly that next cycle, and `out_word` and `out_ovr` hold their values at all other times. The first result appears four edges after reset.
- R9: A synchronous reset returns the phase to 0 and clears every code register, the output word, `out_ovr` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_therm | input | 33 | Comparator thermometer, bit 0 lowest threshold |
| th_hold | output | 1 | Track-and-hold in hold |
| cmp_autozero | output | 1 | Comparators auto-zeroing |
| cmp_strobe | output | 1 | Comparators resolving this clock |
| res_sample | output | 1 | Residue amplifier sampling the input |
| res_amplify | output | 1 | Residue amplifier amplifying |
| tap_sel | output | 5 | Ladder tap chosen by the coarse pass |
| out_valid | output | 1 | One-cycle result strobe |
| out_word | output | 10 | Two's complement result |
| out_ovr | output | 1 | Out-of-range flag of the result |

## Verification
The bench builds the block with the default code width of 5, which gives a 33-bit comparator vector and a 10-bit word. With that width a short run can reach every code value, both saturation directions, and bubbles at many levels. The stimulus is timed so that the comparator input is valid only in the capture and resolve phases and holds junk during the settle phase. A reset in the middle of the run restarts the overlapped pipeline.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_CAPTURE = 2'd0,
    PH_SETTLE  = 2'd1,
    PH_RESOLVE = 2'd2
  } phase_e;
endpackage

// File: rtl/therm_enc.sv
module therm_enc #(
  parameter int CODE_W = 5,
  localparam int NCMP = (1 << CODE_W) + 1
) (
  input  logic [NCMP-1:0]   therm,
  output logic [CODE_W-1:0] code,
  output logic              over,
  output logic              under
);
  always_comb begin
    code  = '0;
    over  = therm[NCMP-1];
    under = (therm == '0);
    // highest asserted bit wins, so a single low bit below it is harmless
    for (int i = 0; i < NCMP - 1; i++)
      if (therm[i]) code = CODE_W'(i);
    if (over) code = '1;
  end

  always_comb begin
    if (!over && !under)
      assert_enc_top_R2: assert (therm[code]);
  end
endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import adc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e ph,
  output logic   th_hold,
  output logic   cmp_autozero,
  output logic   cmp_strobe,
  output logic   res_sample,
  output logic   res_amplify
);
  always_ff @(posedge clk) begin
    if (rst) ph <= PH_CAPTURE;
    else begin
      case (ph)
        PH_CAPTURE: ph <= PH_SETTLE;
        PH_SETTLE:  ph <= PH_RESOLVE;
        default:    ph <= PH_CAPTURE;
      endcase
    end
  end

  always_comb begin
    th_hold      = (ph == PH_CAPTURE);
    res_sample   = (ph == PH_CAPTURE);
    cmp_autozero = (ph == PH_SETTLE);
    cmp_strobe   = (ph == PH_CAPTURE) || (ph == PH_RESOLVE);
    res_amplify  = (ph == PH_SETTLE) || (ph == PH_RESOLVE);
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RESOLVE) |=> (ph == PH_CAPTURE));
  assert_hold_one_clock_R1: assert property (@(posedge clk) disable iff (rst)
    th_hold |=> !th_hold);
endmodule

// File: rtl/two_step_adc_seq.sv
module two_step_adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 5,
  localparam int NCMP = (1 << CODE_W) + 1,
  localparam int WORD_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCMP-1:0]   cmp_therm,
  output logic              th_hold,
  output logic              cmp_autozero,
  output logic              cmp_strobe,
  output logic              res_sample,
  output logic              res_amplify,
  output logic [CODE_W-1:0] tap_sel,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_ovr
);
  phase_e ph;
  logic [CODE_W-1:0] enc_code, fine_q;
  logic enc_over, enc_under, coarse_ovr, fine_ovr, fine_ok;
  logic [WORD_W-1:0] word_next;
  logic ovr_next;

  phase_gen u_phase (
    .clk(clk), .rst(rst), .ph(ph), .th_hold(th_hold),
    .cmp_autozero(cmp_autozero), .cmp_strobe(cmp_strobe),
    .res_sample(res_sample), .res_amplify(res_amplify)
  );

  therm_enc #(.CODE_W(CODE_W)) u_enc (
    .therm(cmp_therm), .code(enc_code), .over(enc_over), .under(enc_under)
  );

  // assemble from the held coarse/fine pair before the next coarse lands
  always_comb begin
    if (coarse_ovr) begin
      word_next = tap_sel[CODE_W-1] ? {1'b0, {(WORD_W-1){1'b1}}}
                                    : {1'b1, {(WORD_W-1){1'b0}}};
      ovr_next  = 1'b1;
    end else begin
      word_next = {~tap_sel[CODE_W-1], tap_sel[CODE_W-2:0], fine_q};
      ovr_next  = fine_ovr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_sel    <= '0;
      coarse_ovr <= 1'b0;
      fine_q     <= '0;
      fine_ovr   <= 1'b0;
      fine_ok    <= 1'b0;
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_ovr    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (ph == PH_CAPTURE) begin
        if (fine_ok) begin
          out_word  <= word_next;
          out_ovr   <= ovr_next;
          out_valid <= 1'b1;
        end
        tap_sel    <= enc_code;
        coarse_ovr <= enc_over | enc_under;
      end
      if (ph == PH_RESOLVE) begin
        fine_q   <= enc_code;
        fine_ovr <= enc_over | enc_under;
        fine_ok  <= 1'b1;
      end
    end
  end

  assert_tap_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_CAPTURE) |=> $stable(tap_sel));
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_word_held_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_word) && $stable(out_ovr));
  assert_valid_in_settle_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ph == PH_SETTLE));
endmodule

// File: tb/tb_two_step_adc_seq.sv
module tb_two_step_adc_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [32:0] cmp_therm;
  logic th_hold, cmp_autozero, cmp_strobe, res_sample, res_amplify;
  logic [4:0] tap_sel;
  logic out_valid;
  logic [9:0] out_word;
  logic out_ovr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  two_step_adc_seq dut (
    .clk(clk), .rst(rst), .cmp_therm(cmp_therm), .th_hold(th_hold),
    .cmp_autozero(cmp_autozero), .cmp_strobe(cmp_strobe),
    .res_sample(res_sample), .res_amplify(res_amplify), .tap_sel(tap_sel),
    .out_valid(out_valid), .out_word(out_word), .out_ovr(out_ovr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // level k: bits 0..k high; k=-1 none, k=32 all
  function automatic logic [32:0] mk_therm(int k, bit bubble);
    logic [32:0] t = '0;
    for (int i = 0; i <= k && i < 33; i++) t[i] = 1'b1;
    if (bubble && k >= 2 && k <= 31) t[k-1] = 1'b0;
    return t;
  endfunction

  function automatic int lvl_code(int k);
    if (k < 0) return 0;
    if (k >= 32) return 31;
    return k;
  endfunction

  function automatic bit lvl_ovr(int k);
    return (k < 0) || (k >= 32);
  endfunction

  function automatic int coarse_lvl(int n);
    case (n)
      0: return -1;
      1: return 32;
      2: return 0;
      3: return 31;
      4: return 15;
      5: return 16;
      default: return (n * 7) % 34 - 1;
    endcase
  endfunction

  // model state
  int m_ph, m_tap, m_cov, m_ck, m_fq, m_fov, m_fok, m_valid, m_word, m_ovr;
  int conv;
  int cur_k;

  task automatic model_reset();
    m_ph = 0; m_tap = 0; m_cov = 0; m_ck = 0; m_fq = 0; m_fov = 0;
    m_fok = 0; m_valid = 0; m_word = 0; m_ovr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cmp_therm = '0;
    model_reset();
    conv = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: state right after reset
    chk("R9 valid", out_valid, 0);
    chk("R9 word", out_word, 0);
    chk("R9 ovr", out_ovr, 0);
    chk("R9 tap", tap_sel, 0);
    for (int cyc = 0; cyc < 240; cyc++) begin
      bit do_rst;
      bit bub;
      int fk;
      // compare outputs against the model
      chk("R1 th_hold", th_hold, m_ph == 0);
      chk("R1 res_sample", res_sample, m_ph == 0);
      chk("R1 cmp_autozero", cmp_autozero, m_ph == 1);
      chk("R1 cmp_strobe", cmp_strobe, m_ph != 1);
      chk("R1 res_amplify", res_amplify, m_ph != 0);
      chk("R4 tap_sel", tap_sel, m_tap);
      chk("R8 out_valid", out_valid, m_valid);
      chk(m_cov ? "R7 out_word" : "R6 out_word", out_word, m_word);
      chk(m_cov ? "R7 out_ovr" : "R6 out_ovr", out_ovr, m_ovr);
      do_rst = (cyc == 131 || cyc == 132);
      rst = do_rst;
      bub = (conv % 4 == 1);
      if (m_ph == 0) begin
        cur_k = coarse_lvl(conv);
        cmp_therm = mk_therm(cur_k, bub);      // R2 bubble, R3 ends
      end else if (m_ph == 2) begin
        fk = (conv * 11) % 34 - 1;
        cmp_therm = mk_therm(fk, bub);
      end else begin
        cmp_therm = {cyc[0], 32'hA5C3_0F96 ^ cyc};  // R5: ignored junk
      end
      if (do_rst) begin
        model_reset();
      end else begin
        m_valid = 0;
        if (m_ph == 0) begin
          if (m_fok != 0) begin
            if (m_cov != 0) begin
              m_word = (m_ck < 0) ? 10'h200 : 10'h1FF;
              m_ovr = 1;
            end else begin
              m_word = ((m_tap ^ 16) << 5) | m_fq;
              m_ovr = m_fov;
            end
            m_valid = 1;
          end
          m_ck = cur_k;
          m_tap = lvl_code(cur_k);
          m_cov = lvl_ovr(cur_k);
          conv++;
        end else if (m_ph == 2) begin
          m_fq = lvl_code(fk);
          m_fov = lvl_ovr(fk);
          m_fok = 1;
        end
        m_ph = (m_ph + 1) % 3;
      end
      @(posedge clk);
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule